// File: doc/BRIEF.md
# Walsh Series Waveform Synthesizer

This block rebuilds one period of a periodic digital waveform from its Walsh spectrum. A parallel vector supplies one expansion coefficient for each Walsh index. At every sample position the block adds each coefficient with the sign that the matching Walsh function takes at that position. It then drops the fractional scaling and presents the result as one signed sample. The waveform repeats after a fixed number of samples.

The Walsh signs come from a small generator driven by the sample position counter. Rademacher square waves are taken from the bits of the position, and each Walsh function is the product of the Rademacher waves chosen by the bits of its index. A typical use regenerates the product of two sampled signals. The spectrum of the product is computed elsewhere and held on the coefficient inputs. A sample-rate strobe then steps the block through the period, one output sample per strobe.

Top module: `walsh_synth`

## Requirements
- R1: While reset is asserted and after it is released, `sampleOut` is 0, `samplePos` is 0 and `periodStart` is 0.
- R2: On a strobe with enable high, `sampleOut` takes the value (Σn sgn(n,p)·K_n) / NUM_SAMPLES. K_n is the two's-complement value in `coefVec[n*COEF_W +: COEF_W]`, read as a coefficient with log2(NUM_SAMPLES) fractional bits, and p is `samplePos` before the strobe. sgn(n,p) is −1 when the parity of (n AND bit-reverse(p)) is odd, and +1 otherwise.
- R3: For coefficients taken from an integer waveform, the fractional bits that the rescaling removes are zero. The integer result also fits in the output width without overflow.
- R4: When the coefficients are the Walsh spectrum of the sample-by-sample product of two signals, every regenerated sample equals that product exactly.
- R5: `samplePos` advances by one on each enabled strobe and wraps from NUM_SAMPLES−1 to 0.
- R6: `periodStart` is 1 exactly when `sampleOut` holds the sample taken at position 0. It is 0 after a strobe taken at any other position.
- R7: Between strobes, `sampleOut`, `periodStart` and `samplePos` hold their values.
- R8: One clock after enable is low, `sampleOut` is 0, `samplePos` is 0 and `periodStart` is 0. Strobes arriving while enable is low change nothing.
- R9: `sampleOut` is 2(IN_W−1)+1 bits wide. It carries the full range ±(2^(IN_W−1)−1)² of products of two IN_W-bit samples limited to that magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces the output to zero and parks the position counter at 0 |
| sampleStrobe | input | 1 | One-cycle strobe at the sample rate |
| coefVec | input | NUM_SAMPLES*COEF_W | Signed Walsh coefficients, index n at bits [n*COEF_W +: COEF_W] |
| sampleOut | output | 2*(IN_W-1)+1 | Regenerated signed sample |
| samplePos | output | log2(NUM_SAMPLES) | Position of the next sample to be produced |
| periodStart | output | 1 | High while `sampleOut` holds the position-0 sample |

## Verification
The checks on the rescaling and the output range assume that the coefficients are the exact Walsh spectrum of an integer waveform whose samples fit the output width. They also assume that `coefVec` changes only when the position counter is at 0. The stimulus builds every coefficient set either from integer sample products, with each factor limited to ±127, or from hand-picked multiples of NUM_SAMPLES. It loads new coefficients only at period boundaries. The strobe is always a single cycle with idle cycles after it, so the hold check sees true gaps between strobes.

// File: rtl/walsh_synth_pkg.sv
package walsh_synth_pkg;
  typedef struct packed {
    logic load;   // capture a new sample this cycle
    logic clear;  // block disabled: force outputs to zero
    logic first;  // current position is the start of a period
  } synthStrobe_t;
endpackage

// File: rtl/walsh_synth_ctrl.sv
module walsh_synth_ctrl
  import walsh_synth_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  localparam int LOG2S = $clog2(NUM_SAMPLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sampleStrobe,
  output logic [LOG2S-1:0] pos,
  output synthStrobe_t     strobes
);
  localparam logic [LOG2S-1:0] LAST_POS = LOG2S'(NUM_SAMPLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (!enable) begin
      pos <= '0;
    end else if (sampleStrobe) begin
      pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  always_comb begin
    strobes.load  = enable & sampleStrobe;
    strobes.clear = ~enable;
    strobes.first = (pos == '0);
  end
endmodule

// File: rtl/walsh_sign_gen.sv
module walsh_sign_gen #(
  parameter int NUM_SAMPLES = 8,
  localparam int LOG2S = $clog2(NUM_SAMPLES)
) (
  input  logic [LOG2S-1:0]       pos,
  output logic [NUM_SAMPLES-1:0] negMask
);
  // radWave[i] is the Rademacher wave of order i+1: it is negative when
  // position bit (LOG2S-1-i) is set.
  logic [LOG2S-1:0] radWave;

  for (genvar i = 0; i < LOG2S; i++) begin : g_rad
    assign radWave[i] = pos[LOG2S-1-i];
  end

  // Walsh index n multiplies the Rademacher waves picked by its bits.
  for (genvar n = 0; n < NUM_SAMPLES; n++) begin : g_walsh
    localparam logic [LOG2S-1:0] IDX = LOG2S'(n);
    assign negMask[n] = ^(IDX & radWave);
  end
endmodule

// File: rtl/walsh_synth_dp.sv
module walsh_synth_dp
  import walsh_synth_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  parameter int COEF_W = 19,
  parameter int OUT_W = 15,
  localparam int LOG2S = $clog2(NUM_SAMPLES),
  localparam int ACC_W = COEF_W + LOG2S
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  synthStrobe_t                  strobes,
  input  logic [NUM_SAMPLES-1:0]        negMask,
  input  logic [NUM_SAMPLES*COEF_W-1:0] coefVec,
  output logic [ACC_W-1:0]              rawSum,
  output logic [OUT_W-1:0]              sampleOut,
  output logic                          periodStart
);
  logic [ACC_W-1:0] termExt [NUM_SAMPLES];

  for (genvar n = 0; n < NUM_SAMPLES; n++) begin : g_term
    logic [COEF_W-1:0] coef;
    assign coef       = coefVec[n*COEF_W +: COEF_W];
    assign termExt[n] = {{LOG2S{coef[COEF_W-1]}}, coef};
  end

  always_comb begin
    rawSum = '0;
    for (int n = 0; n < NUM_SAMPLES; n++) begin
      rawSum = negMask[n] ? rawSum - termExt[n] : rawSum + termExt[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleOut   <= '0;
      periodStart <= 1'b0;
    end else if (strobes.clear) begin
      sampleOut   <= '0;
      periodStart <= 1'b0;
    end else if (strobes.load) begin
      sampleOut   <= rawSum[LOG2S +: OUT_W];
      periodStart <= strobes.first;
    end
  end
endmodule

// File: rtl/walsh_synth.sv
module walsh_synth
  import walsh_synth_pkg::*;
#(
  parameter int NUM_SAMPLES = 8,
  parameter int IN_W = 8,
  localparam int LOG2S = $clog2(NUM_SAMPLES),
  localparam int OUT_W = 2 * (IN_W - 1) + 1,
  localparam int COEF_W = OUT_W + LOG2S + 1,
  localparam int ACC_W = COEF_W + LOG2S
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic                          sampleStrobe,
  input  logic [NUM_SAMPLES*COEF_W-1:0] coefVec,
  output logic [OUT_W-1:0]              sampleOut,
  output logic [LOG2S-1:0]              samplePos,
  output logic                          periodStart
);
  synthStrobe_t           strobes;
  logic [NUM_SAMPLES-1:0] negMask;
  logic [ACC_W-1:0]       rawSum;

  walsh_synth_ctrl #(.NUM_SAMPLES(NUM_SAMPLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sampleStrobe(sampleStrobe),
    .pos(samplePos), .strobes(strobes)
  );

  walsh_sign_gen #(.NUM_SAMPLES(NUM_SAMPLES)) u_sign (
    .pos(samplePos), .negMask(negMask)
  );

  walsh_synth_dp #(.NUM_SAMPLES(NUM_SAMPLES), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .negMask(negMask),
    .coefVec(coefVec), .rawSum(rawSum), .sampleOut(sampleOut),
    .periodStart(periodStart)
  );
endmodule

// File: rtl/walsh_synth_chk.sv
module walsh_synth_chk #(
  parameter int NUM_SAMPLES = 8,
  parameter int OUT_W = 15,
  parameter int ACC_W = 22,
  localparam int LOG2S = $clog2(NUM_SAMPLES),
  localparam int TOP_W = ACC_W - LOG2S - OUT_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             sampleStrobe,
  input logic [ACC_W-1:0] rawSum,
  input logic [OUT_W-1:0] sampleOut,
  input logic [LOG2S-1:0] samplePos,
  input logic             periodStart
);
  localparam logic [LOG2S-1:0] LAST_POS = LOG2S'(NUM_SAMPLES - 1);

  logic [LOG2S-1:0] fracBits;
  logic [TOP_W-1:0] topBits;
  assign fracBits = rawSum[LOG2S-1:0];
  assign topBits  = rawSum[ACC_W-1 -: TOP_W];

  // R3: removed fraction is zero on every captured sample
  p_frac_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleStrobe) |-> (fracBits == '0));

  // R3, R9: integer result fits the output width
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleStrobe) |-> (topBits == '0 || topBits == '1));

  // R5: advance by one
  p_pos_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleStrobe && samplePos != LAST_POS) |=> (samplePos == $past(samplePos) + 1'b1));

  // R5: wrap at the end of the period
  p_pos_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleStrobe && samplePos == LAST_POS) |=> (samplePos == '0));

  // R6: flag follows the position the sample was taken at
  p_period_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleStrobe) |=> (periodStart == ($past(samplePos) == '0)));

  // R7: hold between strobes
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sampleStrobe) |=> ($stable(sampleOut) && $stable(samplePos) && $stable(periodStart)));

  // R8: disabled state
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sampleOut == '0 && samplePos == '0 && !periodStart));
endmodule

bind walsh_synth walsh_synth_chk #(
  .NUM_SAMPLES(NUM_SAMPLES), .OUT_W(OUT_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sampleStrobe(sampleStrobe),
  .rawSum(rawSum), .sampleOut(sampleOut), .samplePos(samplePos),
  .periodStart(periodStart)
);

// File: tb/tb_walsh_synth.sv
module tb_walsh_synth;
  localparam int NS = 8;
  localparam int IN_W = 8;
  localparam int LOG2S = $clog2(NS);
  localparam int OUT_W = 2 * (IN_W - 1) + 1;
  localparam int COEF_W = OUT_W + LOG2S + 1;

  typedef struct {
    int    sample;
    bit    first;
    int    nextPos;
    string req;
  } expItem_t;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     enable = 1'b0;
  logic                     sampleStrobe = 1'b0;
  logic [NS*COEF_W-1:0]     coefVec = '0;
  logic [OUT_W-1:0]         sampleOut;
  logic [LOG2S-1:0]         samplePos;
  logic                     periodStart;

  int checks = 0;
  int fails = 0;
  int curPos = 0;
  int lastSample = 0;
  int hVal [NS];
  int rawC [NS];
  expItem_t expQ [$];

  always #10 clk = ~clk;  // 50 MHz

  walsh_synth #(.NUM_SAMPLES(NS), .IN_W(IN_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sampleStrobe(sampleStrobe),
    .coefVec(coefVec), .sampleOut(sampleOut), .samplePos(samplePos),
    .periodStart(periodStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int wSign(input int n, input int p);
    int rev = 0;
    int par;
    for (int b = 0; b < LOG2S; b++) rev |= ((p >> b) & 1) << (LOG2S - 1 - b);
    par = $countones(n & rev) % 2;
    return par ? -1 : 1;
  endfunction

  task automatic loadCoefs();
    for (int n = 0; n < NS; n++) coefVec[n*COEF_W +: COEF_W] = COEF_W'(rawC[n]);
  endtask

  task automatic strobeOnce(input int expS, input string req);
    expItem_t it;
    it.sample  = expS;
    it.first   = (curPos == 0);
    it.nextPos = (curPos + 1) % NS;
    it.req     = req;
    expQ.push_back(it);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    repeat (2) @(negedge clk);
    curPos = (curPos + 1) % NS;
    lastSample = expS;
  endtask

  // Spectrum of hVal computed in the bench, expected output = hVal (R4)
  task automatic runProduct(input string req);
    for (int n = 0; n < NS; n++) begin
      rawC[n] = 0;
      for (int p = 0; p < NS; p++) rawC[n] += hVal[p] * wSign(n, p);
    end
    loadCoefs();
    for (int p = 0; p < NS; p++) strobeOnce(hVal[p], req);
  endtask

  // Direct coefficients, expected output from the series sum (R2)
  task automatic runCoefs(input string req);
    loadCoefs();
    for (int p = 0; p < NS; p++) begin
      int s = 0;
      for (int n = 0; n < NS; n++) s += rawC[n] * wSign(n, p);
      strobeOnce(s / NS, req);
    end
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      if (enable && sampleStrobe) begin
        expItem_t e;
        @(negedge clk);
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected sample", $signed(sampleOut), 0);
        end else begin
          e = expQ.pop_front();
          check($signed(sampleOut) == e.sample, e.req, $signed(sampleOut), e.sample);
          check(periodStart == e.first, "R6 periodStart", periodStart, e.first);
          check(int'(samplePos) == e.nextPos, "R5 samplePos", samplePos, e.nextPos);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int lfsr = 8'h5A;
    repeat (3) @(negedge clk);
    check(sampleOut == '0, "R1 reset sampleOut", $signed(sampleOut), 0);
    check(samplePos == '0, "R1 reset samplePos", samplePos, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(periodStart == 1'b0, "R1 reset periodStart", periodStart, 0);
    check(sampleOut == '0, "R1 after release sampleOut", $signed(sampleOut), 0);

    enable = 1'b1;
    @(negedge clk);

    // R2: single Walsh function, then a mix
    for (int n = 0; n < NS; n++) rawC[n] = 0;
    rawC[3] = 100 * NS;
    runCoefs("R2 single coefficient");
    for (int n = 0; n < NS; n++) rawC[n] = 0;
    rawC[0] = 50 * NS;
    rawC[5] = -20 * NS;
    rawC[6] = 7 * NS;
    runCoefs("R2 mixed coefficients");

    // R7: hold after a strobe
    repeat (4) @(negedge clk);
    check($signed(sampleOut) == lastSample, "R7 hold sampleOut", $signed(sampleOut), lastSample);
    check(int'(samplePos) == curPos, "R7 hold samplePos", samplePos, curPos);

    // R4: ramp times ramp
    for (int p = 0; p < NS; p++) hVal[p] = (10 * p - 35) * (3 * p + 1);
    runProduct("R4 ramp product");

    // R9: extreme magnitudes
    for (int p = 0; p < NS; p++) hVal[p] = ((p % 2) ? -127 : 127) * (((p / 2) % 2) ? -127 : 127);
    runProduct("R9 extreme product");

    // R4: pseudo-random signals in -127..127
    for (int p = 0; p < NS; p++) begin
      int xa, yb;
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
      xa = (lfsr % 255) - 127;
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
      yb = (lfsr % 255) - 127;
      hVal[p] = xa * yb;
    end
    runProduct("R4 random product");

    // R8: disable mid-period with strobes present
    for (int p = 0; p < 5; p++) strobeOnce(hVal[p], "R4 partial period");
    check(samplePos == 3'd5, "R5 mid-period position", samplePos, 5);
    enable = 1'b0;
    sampleStrobe = 1'b1;
    repeat (2) @(negedge clk);
    sampleStrobe = 1'b0;
    check(sampleOut == '0, "R8 disabled sampleOut", $signed(sampleOut), 0);
    check(samplePos == '0, "R8 disabled samplePos", samplePos, 0);
    check(periodStart == 1'b0, "R8 disabled periodStart", periodStart, 0);
    curPos = 0;
    enable = 1'b1;
    @(negedge clk);
    check(sampleOut == '0, "R8 zero held after re-enable", $signed(sampleOut), 0);

    // R4, R5, R6: full period after re-enable starts at position 0
    runProduct("R4 product after re-enable");
    check(samplePos == '0, "R5 wrap to zero", samplePos, 0);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all samples observed", expQ.size(), 0);
    finishRun();
  end
endmodule